// File: doc/BRIEF.md
# Three-Domain Stimulus Chain Buffer

This block carries stimulus words for an emulation harness. Words enter at a host-side write port and leave at a device-under-test input port. The words pass through three cascaded buffer stages, and each interface runs on its own clock. The host clock writes into a small entry buffer. A middle clock drains the entry buffer into a deep bulk buffer, which stands in for external bulk memory. The same middle clock moves words from the bulk buffer into a small exit buffer. The device-under-test clock reads the exit buffer through a valid/ready handshake, so stimuli are applied one transaction at a time rather than on fixed cycles.

Both clock crossings use Gray-coded pointers passed through synchronizer chains of configurable length. The host port never loses a word. When the entry buffer has no room, `host_full` rises and a write in that cycle is simply not taken. The harness instantiates one copy of this block for each device interface. The data width and all three depths are elaboration-time parameters.

Top module: `stim_port_chain`

## Requirements
- R1: In the first clock of each domain after its reset, `host_full` is 0 and `dut_valid` is 0, so all stages start empty.
- R2: Each word accepted at the host port appears exactly once at the device port, in the order it was accepted. No other word appears there.
- R3: A host write is accepted only when `host_full` is 0 at that host clock edge. A write made while `host_full` is 1 has no effect: that word never reaches the device port.
- R4: While `dut_valid` is 1 and `dut_ready` is 0, `dut_valid` stays 1 and `dut_data` stays unchanged at the next device clock edge.
- R5: `dut_valid` is 0 whenever no accepted word is waiting in the chain. The read side does not advance while `dut_valid` is 0.
- R6: While `dut_ready` is held at 0, the chain absorbs exactly HOST_DEPTH + BULK_DEPTH + DUT_DEPTH words, which is 76 with the default depths 8, 64 and 4. After that, `host_full` stays 1.
- R7: Once the device side drains the chain, `host_full` returns to 0.
- R8: The pointer copies that cross a clock boundary change in at most one bit per clock of their own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host-side clock |
| host_rst | input | 1 | Synchronous active-high reset, host domain |
| host_wr | input | 1 | Host write request |
| host_data | input | DATA_W | Host write word |
| host_full | output | 1 | Entry buffer full; a write in this cycle is not taken |
| bulk_clk | input | 1 | Bulk-buffer clock |
| bulk_rst | input | 1 | Synchronous active-high reset, bulk domain |
| dut_clk | input | 1 | Device-under-test clock |
| dut_rst | input | 1 | Synchronous active-high reset, device domain |
| dut_valid | output | 1 | A word is presented to the device |
| dut_data | output | DATA_W | Word presented to the device |
| dut_ready | input | 1 | Device takes the presented word at this edge |

## Verification
The assertions check these behaviours on every cycle: the reset values, that a write made while full leaves the entry pointer unchanged, that the output holds steady under a stall, that the read pointer stays still while nothing is presented, and that every crossing pointer moves in single-bit steps. End-to-end ordering and exact delivery, the total capacity under a long stall, and the release of `host_full` after draining span all three clocks. Only the bench's scenarios can show these, by comparing its queue model against the output under steady, random and stalled ready patterns.

// File: rtl/stim_chain_pkg.sv
package stim_chain_pkg;
   localparam int MIN_DEPTH = 4;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stg[0] <= '0;
               else     stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stg[i] <= '0;
               else     stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
   import stim_chain_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = AW + 1
) (
   input  logic              wclk,
   input  logic              wrst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   output logic [PW-1:0]     wr_gray,
   input  logic              rclk,
   input  logic              rrst,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty,
   output logic [PW-1:0]     rd_gray
);
   generate
      if (!is_pow2(DEPTH) || DEPTH < MIN_DEPTH) begin : g_bad_depth
         $error("xclk_fifo: DEPTH must be a power of two and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("xclk_fifo: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0] wbin, wbin_nxt, wgray_nxt, rq_w;
   logic [PW-1:0] rbin, rbin_nxt, rgray_nxt, wq_r;
   logic          full_nxt, empty_nxt;

   // write domain
   assign wbin_nxt  = wbin + PW'(wr_en & ~wr_full);
   assign wgray_nxt = wbin_nxt ^ (wbin_nxt >> 1);
   assign full_nxt  = (wgray_nxt == {~rq_w[PW-1:PW-2], rq_w[PW-3:0]});

   always_ff @(posedge wclk) begin
      if (wrst) begin
         wbin    <= '0;
         wr_gray <= '0;
         wr_full <= 1'b0;
      end else begin
         wbin    <= wbin_nxt;
         wr_gray <= wgray_nxt;
         wr_full <= full_nxt;
      end
   end

   always_ff @(posedge wclk) begin
      if (wr_en && !wr_full) mem[wbin[AW-1:0]] <= wr_data;
   end

   cdc_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
      .clk(wclk), .rst(wrst), .d(rd_gray), .q(rq_w)
   );

   // read domain
   assign rbin_nxt  = rbin + PW'(rd_en & ~rd_empty);
   assign rgray_nxt = rbin_nxt ^ (rbin_nxt >> 1);
   assign empty_nxt = (rgray_nxt == wq_r);

   always_ff @(posedge rclk) begin
      if (rrst) begin
         rbin     <= '0;
         rd_gray  <= '0;
         rd_empty <= 1'b1;
      end else begin
         rbin     <= rbin_nxt;
         rd_gray  <= rgray_nxt;
         rd_empty <= empty_nxt;
      end
   end

   assign rd_data = mem[rbin[AW-1:0]];

   cdc_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk(rclk), .rst(rrst), .d(wr_gray), .q(wq_r)
   );
endmodule

// File: rtl/bulk_fifo.sv
module bulk_fifo
   import stim_chain_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty
);
   generate
      if (!is_pow2(DEPTH) || DEPTH < MIN_DEPTH) begin : g_bad_depth
         $error("bulk_fifo: DEPTH must be a power of two and at least 4");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, rp;
   logic [CW-1:0]     cnt;
   logic              do_w, do_r;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign do_w  = wr_en && !full;
   assign do_r  = rd_en && !empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_w) wp <= wp + 1'b1;
         if (do_r) rp <= rp + 1'b1;
         cnt <= cnt + CW'(do_w) - CW'(do_r);
      end
   end

   always_ff @(posedge clk) begin
      if (do_w) mem[wp] <= wr_data;
   end

   assign rd_data = mem[rp];
endmodule

// File: rtl/stim_port_chain.sv
module stim_port_chain
   import stim_chain_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int HOST_DEPTH  = 8,
   parameter int BULK_DEPTH  = 64,
   parameter int DUT_DEPTH   = 4,
   parameter int SYNC_STAGES = 2,
   localparam int H_PW       = $clog2(HOST_DEPTH) + 1,
   localparam int D_PW       = $clog2(DUT_DEPTH) + 1
) (
   input  logic              host_clk,
   input  logic              host_rst,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_data,
   output logic              host_full,
   input  logic              bulk_clk,
   input  logic              bulk_rst,
   input  logic              dut_clk,
   input  logic              dut_rst,
   output logic              dut_valid,
   output logic [DATA_W-1:0] dut_data,
   input  logic              dut_ready
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("stim_port_chain: DATA_W must be at least 1");
      end
   endgenerate

   logic [H_PW-1:0]   s1_wgray, s1_rgray;
   logic [D_PW-1:0]   s3_wgray, s3_rgray;
   logic [DATA_W-1:0] s1_rdata, s2_rdata;
   logic              s1_empty, s1_move;
   logic              s2_full, s2_empty, s2_move;
   logic              s3_full, s3_empty;

   // entry stage: host -> bulk domain
   xclk_fifo #(.DATA_W(DATA_W), .DEPTH(HOST_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_entry (
      .wclk(host_clk), .wrst(host_rst), .wr_en(host_wr), .wr_data(host_data),
      .wr_full(host_full), .wr_gray(s1_wgray),
      .rclk(bulk_clk), .rrst(bulk_rst), .rd_en(s1_move), .rd_data(s1_rdata),
      .rd_empty(s1_empty), .rd_gray(s1_rgray)
   );

   // word moves only when upstream holds one and downstream has room
   assign s1_move = !s1_empty && !s2_full;

   bulk_fifo #(.DATA_W(DATA_W), .DEPTH(BULK_DEPTH)) u_bulk (
      .clk(bulk_clk), .rst(bulk_rst),
      .wr_en(s1_move), .wr_data(s1_rdata), .full(s2_full),
      .rd_en(s2_move), .rd_data(s2_rdata), .empty(s2_empty)
   );

   assign s2_move = !s2_empty && !s3_full;

   // exit stage: bulk -> device domain
   xclk_fifo #(.DATA_W(DATA_W), .DEPTH(DUT_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_exit (
      .wclk(bulk_clk), .wrst(bulk_rst), .wr_en(s2_move), .wr_data(s2_rdata),
      .wr_full(s3_full), .wr_gray(s3_wgray),
      .rclk(dut_clk), .rrst(dut_rst), .rd_en(dut_ready), .rd_data(dut_data),
      .rd_empty(s3_empty), .rd_gray(s3_rgray)
   );

   assign dut_valid = !s3_empty;
endmodule

// File: rtl/stim_chain_chk.sv
module stim_chain_chk #(
   parameter int DATA_W = 16,
   parameter int P1_W   = 4,
   parameter int P3_W   = 3
) (
   input logic              host_clk,
   input logic              host_rst,
   input logic              host_wr,
   input logic              host_full,
   input logic              bulk_clk,
   input logic              bulk_rst,
   input logic              dut_clk,
   input logic              dut_rst,
   input logic              dut_valid,
   input logic              dut_ready,
   input logic [DATA_W-1:0] dut_data,
   input logic [P1_W-1:0]   s1_wgray,
   input logic [P1_W-1:0]   s1_rgray,
   input logic [P3_W-1:0]   s3_wgray,
   input logic [P3_W-1:0]   s3_rgray
);
   // R1
   host_reset_chk: assert property (@(posedge host_clk) host_rst |=> !host_full);
   // R1
   dut_reset_chk: assert property (@(posedge dut_clk) dut_rst |=> !dut_valid);
   // R3
   no_overflow_chk: assert property (@(posedge host_clk) disable iff (host_rst)
      (host_wr && host_full) |=> $stable(s1_wgray));
   // R4
   valid_hold_chk: assert property (@(posedge dut_clk) disable iff (dut_rst)
      (dut_valid && !dut_ready) |=> (dut_valid && $stable(dut_data)));
   // R5
   no_underflow_chk: assert property (@(posedge dut_clk) disable iff (dut_rst)
      !dut_valid |=> $stable(s3_rgray));
   // R8
   entry_wptr_step_chk: assert property (@(posedge host_clk) disable iff (host_rst)
      $countones(s1_wgray ^ $past(s1_wgray)) <= 1);
   // R8
   entry_rptr_step_chk: assert property (@(posedge bulk_clk) disable iff (bulk_rst)
      $countones(s1_rgray ^ $past(s1_rgray)) <= 1);
   // R8
   exit_wptr_step_chk: assert property (@(posedge bulk_clk) disable iff (bulk_rst)
      $countones(s3_wgray ^ $past(s3_wgray)) <= 1);
   // R8
   exit_rptr_step_chk: assert property (@(posedge dut_clk) disable iff (dut_rst)
      $countones(s3_rgray ^ $past(s3_rgray)) <= 1);
endmodule

bind stim_port_chain stim_chain_chk #(.DATA_W(DATA_W), .P1_W(H_PW), .P3_W(D_PW)) u_chk (
   .host_clk(host_clk), .host_rst(host_rst), .host_wr(host_wr), .host_full(host_full),
   .bulk_clk(bulk_clk), .bulk_rst(bulk_rst),
   .dut_clk(dut_clk), .dut_rst(dut_rst), .dut_valid(dut_valid), .dut_ready(dut_ready),
   .dut_data(dut_data),
   .s1_wgray(s1_wgray), .s1_rgray(s1_rgray), .s3_wgray(s3_wgray), .s3_rgray(s3_rgray)
);

// File: tb/test_stim_port_chain.sv
`timescale 1ns/1ps
module test_stim_port_chain;
   localparam int DATA_W   = 16;
   localparam int CAPACITY = 8 + 64 + 4;

   logic              host_clk = 1'b0, bulk_clk = 1'b0, dut_clk = 1'b0;
   logic              host_rst = 1'b1, bulk_rst = 1'b1, dut_rst = 1'b1;
   logic              host_wr = 1'b0;
   logic [DATA_W-1:0] host_data = '0;
   logic              host_full, dut_valid;
   logic [DATA_W-1:0] dut_data;
   logic              dut_ready = 1'b0;

   int tests = 0;
   int fails = 0;
   int ready_mode = 0;          // 0: always ready, 1: never ready, 2: random
   logic [DATA_W-1:0] exp_q [$];
   logic [15:0] rdy_lfsr = 16'hACE1;
   logic [15:0] dat_lfsr = 16'h1D2B;
   logic              prev_stall = 1'b0;
   logic [DATA_W-1:0] prev_data = '0;

   always #5  host_clk = ~host_clk;   // 100 MHz
   always #4  bulk_clk = ~bulk_clk;
   always #13 dut_clk  = ~dut_clk;

   stim_port_chain #(.DATA_W(DATA_W)) i_stim_port_chain (
      .host_clk(host_clk), .host_rst(host_rst), .host_wr(host_wr), .host_data(host_data),
      .host_full(host_full),
      .bulk_clk(bulk_clk), .bulk_rst(bulk_rst),
      .dut_clk(dut_clk), .dut_rst(dut_rst), .dut_valid(dut_valid), .dut_data(dut_data),
      .dut_ready(dut_ready)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   function automatic logic [15:0] lfsr_step(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   // device-side model: drives ready, compares each transfer against the queue
   always @(negedge dut_clk) begin
      if (dut_rst) begin
         prev_stall = 1'b0;
         dut_ready  = 1'b0;
      end else begin
         logic nr;
         rdy_lfsr = lfsr_step(rdy_lfsr);
         nr = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? 1'b0 : rdy_lfsr[0];
         dut_ready = nr;
         if (prev_stall)   // R4 word held under stall
            check(dut_valid && dut_data == prev_data, "R4", {dut_valid, dut_data}, {1'b1, prev_data});
         if (dut_valid)    // R5 nothing presented beyond what was accepted
            check(exp_q.size() != 0, "R5", exp_q.size(), 1);
         if (dut_valid && nr && exp_q.size() != 0) begin
            check(dut_data == exp_q[0], "R2", dut_data, exp_q[0]);
            void'(exp_q.pop_front());
         end
         prev_stall = dut_valid && !nr;
         prev_data  = dut_data;
      end
   end

   task automatic try_write(input logic [DATA_W-1:0] d, output bit acc);
      @(negedge host_clk);
      host_wr   = 1'b1;
      host_data = d;
      acc = !host_full;           // R3 taken only when not full at the edge
      if (acc) exp_q.push_back(d);
   endtask

   task automatic send_word(input logic [DATA_W-1:0] d);
      bit acc;
      acc = 1'b0;
      while (!acc) try_write(d, acc);
   endtask

   task automatic host_idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge host_clk);
         host_wr = 1'b0;
      end
   endtask

   task automatic wait_drain(input string req);
      for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge dut_clk);
      repeat (10) @(negedge dut_clk);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
      check(!dut_valid, "R5", dut_valid, 0);
   endtask

   initial begin
      #2_000_000;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int accepted;
      repeat (20) @(posedge host_clk);
      fork
         begin @(negedge host_clk); host_rst = 1'b0; end
         begin @(negedge bulk_clk); bulk_rst = 1'b0; end
         begin @(negedge dut_clk);  dut_rst  = 1'b0; end
      join
      repeat (3) @(negedge dut_clk);
      // R1 reset state
      check(!host_full, "R1", host_full, 0);
      check(!dut_valid, "R1", dut_valid, 0);

      // steady ready, incrementing burst
      ready_mode = 0;
      for (int i = 0; i < 40; i++) send_word(DATA_W'(16'h1000 + i));
      host_idle(1);
      wait_drain("R2");

      // random ready, random data with gaps (pointer crossings exercised, R8)
      ready_mode = 2;
      for (int i = 0; i < 200; i++) begin
         dat_lfsr = lfsr_step(dat_lfsr);
         send_word(dat_lfsr);
         if (dat_lfsr[3]) host_idle(1);
      end
      host_idle(1);
      ready_mode = 0;
      wait_drain("R2");

      // stalled output: fill to capacity, extra writes must be dropped
      ready_mode = 1;
      repeat (4) @(negedge dut_clk);
      accepted = 0;
      for (int i = 0; i < 600; i++) begin
         bit acc;
         try_write(DATA_W'(16'h8000 + i), acc);
         if (acc) accepted++;
      end
      host_idle(1);
      check(accepted == CAPACITY, "R6", accepted, CAPACITY);
      check(host_full, "R6", host_full, 1);
      check(exp_q.size() == CAPACITY, "R3", exp_q.size(), CAPACITY);
      check(dut_valid, "R4", dut_valid, 1);

      // release: dropped words never appear, order intact
      ready_mode = 0;
      wait_drain("R3");
      repeat (10) @(negedge host_clk);
      check(!host_full, "R7", host_full, 0);

      // one more word after drain
      send_word(16'hBEEF);
      host_idle(1);
      wait_drain("R2");

      finish_run();
   end
endmodule